// File: doc/BRIEF.md
# Dual-Bank Flash Power Fallback Controller

This block sets the power state of two flash banks and of the charge pump they share. Each bank has an active-grace counter. An access to the bank reloads the counter, and the bank stays active while the counter runs down. When the counter reaches zero, the bank moves to its programmed fallback state: sleep, standby or active. When the fallback is active, the bank never leaves the active state.

The pump has its own grace counter. That counter is held at its load value while any bank is active. It begins to count down only once every bank has left the active state. The load value comes from the pump-grace register of whichever controller currently owns the pump. When the pump counter expires, the pump enters sleep if every bank asks for pump sleep and every bank is already asleep. Otherwise the pump enters standby. An access to any bank brings the pump back to active.

Each bank runs a state machine with states BK_ACTIVE, BK_STANDBY and BK_SLEEP. It has these transitions:
- hold-on-access (BK_ACTIVE to BK_ACTIVE)
- expire (BK_ACTIVE to the fallback state once the counter is zero and no access is present)
- wake (BK_STANDBY or BK_SLEEP to BK_ACTIVE on an access)
- follow (a low-power state moves to the current fallback state, which may be active)

The pump state machine has states PS_ACTIVE, PS_STANDBY and PS_SLEEP. It has these transitions:
- hold (PS_ACTIVE while any bank is active or accessed)
- expire (PS_ACTIVE to the pump fallback once its counter is zero)
- wake (a low-power state to PS_ACTIVE on any access or any active bank)
- follow (moves between PS_STANDBY and PS_SLEEP as the sleep conditions change)

Top module: `flash_pwr_fallback`

## Requirements
- R1: After reset, every bank mode and the pump mode read 2'b11 (active), and pump_ready is 1.
- R2: A bank whose fallback code is low-power leaves the active state exactly G+1 cycles after the edge that samples its access, where G is the grace value sampled at that access. It never leaves active in a cycle that follows an access.
- R3: Fallback codes are 2'b00 sleep, 2'b01 standby, 2'b11 active, with 2'b10 treated as active. A bank that drops takes the code of its fallback as its mode. A bank whose fallback is 2'b11 or 2'b10 stays active indefinitely. The mode output never shows 2'b10.
- R4: An access to a bank in standby or sleep makes that bank active on the next cycle and reloads its grace counter.
- R5: A grace value written while the bank's counter is running has no effect on the current countdown. It is used from the next access on.
- R6: The pump counter is held while any bank is active. The pump leaves active exactly P+1 cycles after the cycle in which the last bank left active.
- R7: The pump enters sleep (2'b00) only if every pump sleep-request bit is 1 and every bank is in sleep. Otherwise it falls back to standby (2'b01). A low-power pump follows these conditions cycle by cycle.
- R8: The pump grace value P is the pump-grace field selected by pump_owner (field i occupies bits [8*i+7:8*i] at the default width).
- R9: An access to any bank makes the pump active on the next cycle.
- R10: pump_ready is 1 exactly when pump_mode is 2'b11.
- R11: A bank in standby or sleep that sees no access moves, on the next cycle, to the state its current fallback code names, including active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_access | input | N_BANKS | Per-bank access strobe, one cycle per access |
| bank_fallback | input | 2*N_BANKS | Per-bank fallback code, bank i at [2i+1:2i] |
| bank_grace | input | GRACE_W*N_BANKS | Per-bank active-grace load value |
| pump_grace | input | GRACE_W*N_BANKS | Per-controller pump-grace load value |
| pump_sleep_req | input | N_BANKS | Per-controller pump sleep request |
| pump_owner | input | OWN_W | Index of the controller that owns the pump |
| bank_mode | output | 2*N_BANKS | Per-bank power mode, same code as the fallback |
| pump_mode | output | 2 | Pump power mode, same code |
| pump_ready | output | 1 | High while the pump is active |

## Verification
Every result comes from a registered state. A bank wakes, and the pump wakes, one edge after the edge that samples an access. A bank drops G+1 edges after its access. The pump drops P+1 edges after the last bank drops, which is max(G)+P+2 edges after a joint access. The bench drives inputs on falling edges and reads outputs on falling edges. It counts the falling edges that elapse after an access until an output changes, and compares that count with the arithmetic above, for every grace value, fallback code, bank and owner in the sweep.

// File: rtl/fpf_pkg.sv
package fpf_pkg;

    typedef enum logic [1:0] {
        BK_SLEEP   = 2'b00,
        BK_STANDBY = 2'b01,
        BK_ACTIVE  = 2'b11
    } bank_state_e;

    typedef enum logic [1:0] {
        PS_SLEEP   = 2'b00,
        PS_STANDBY = 2'b01,
        PS_ACTIVE  = 2'b11
    } pump_state_e;

    localparam logic [1:0] MODE_SLEEP   = 2'b00;
    localparam logic [1:0] MODE_STANDBY = 2'b01;
    localparam logic [1:0] MODE_ACTIVE  = 2'b11;

    // Fallback code to bank state; the spare code behaves as active.
    function automatic bank_state_e fallback_to_bank(input logic [1:0] code);
        bank_state_e s;
        case (code)
            MODE_SLEEP:   s = BK_SLEEP;
            MODE_STANDBY: s = BK_STANDBY;
            default:      s = BK_ACTIVE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fpf_grace_counter.sv
module fpf_grace_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (dec && (count_q != '0)) begin
            count_q <= count_q - W'(1);
        end
    end

    always_comb zero = (count_q == '0);
endmodule

// File: rtl/fpf_bank_fsm.sv
module fpf_bank_fsm
    import fpf_pkg::*;
#(
    parameter int GRACE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               access,
    input  logic [1:0]         fallback,
    input  logic [GRACE_W-1:0] grace,
    output logic [1:0]         mode,
    output logic               is_active,
    output logic               is_sleep
);
    bank_state_e state_q, state_d, fb_state;
    logic        cnt_zero;
    logic        cnt_dec;

    always_comb fb_state = fallback_to_bank(fallback);
    always_comb cnt_dec  = (state_q == BK_ACTIVE);

    fpf_grace_counter #(.W(GRACE_W)) u_grace (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (access),
        .load_val (grace),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_ACTIVE: begin
                if (access)        state_d = BK_ACTIVE;  // hold-on-access
                else if (cnt_zero) state_d = fb_state;   // expire
                else               state_d = BK_ACTIVE;
            end
            BK_STANDBY, BK_SLEEP: begin
                if (access) state_d = BK_ACTIVE;         // wake
                else        state_d = fb_state;          // follow
            end
            default: state_d = BK_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BK_ACTIVE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            BK_SLEEP:   mode = MODE_SLEEP;
            BK_STANDBY: mode = MODE_STANDBY;
            default:    mode = MODE_ACTIVE;
        endcase
        is_active = (state_q == BK_ACTIVE);
        is_sleep  = (state_q == BK_SLEEP);
    end
endmodule

// File: rtl/fpf_pump_fsm.sv
module fpf_pump_fsm
    import fpf_pkg::*;
#(
    parameter int GRACE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_access,
    input  logic               any_active,
    input  logic               all_sleep,
    input  logic               all_req,
    input  logic [GRACE_W-1:0] grace,
    output logic [1:0]         mode,
    output logic               ready
);
    pump_state_e state_q, state_d, fb_state;
    logic        busy;
    logic        cnt_zero;
    logic        cnt_dec;

    always_comb begin
        busy     = any_access | any_active;
        fb_state = (all_req && all_sleep) ? PS_SLEEP : PS_STANDBY;
        cnt_dec  = (state_q == PS_ACTIVE) && !busy;
    end

    // Held at the owner's value while busy, counts once all banks idle.
    fpf_grace_counter #(.W(GRACE_W)) u_grace (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (busy),
        .load_val (grace),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_ACTIVE: begin
                if (busy)          state_d = PS_ACTIVE;  // hold
                else if (cnt_zero) state_d = fb_state;   // expire
                else               state_d = PS_ACTIVE;
            end
            PS_STANDBY, PS_SLEEP: begin
                if (busy) state_d = PS_ACTIVE;           // wake
                else      state_d = fb_state;            // follow
            end
            default: state_d = PS_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_ACTIVE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            PS_SLEEP:   mode = MODE_SLEEP;
            PS_STANDBY: mode = MODE_STANDBY;
            default:    mode = MODE_ACTIVE;
        endcase
        ready = (state_q == PS_ACTIVE);
    end
endmodule

// File: rtl/flash_pwr_fallback.sv
module flash_pwr_fallback #(
    parameter int N_BANKS = 2,
    parameter int GRACE_W = 8,
    parameter int OWN_W   = $clog2(N_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_BANKS-1:0]         bank_access,
    input  logic [2*N_BANKS-1:0]       bank_fallback,
    input  logic [GRACE_W*N_BANKS-1:0] bank_grace,
    input  logic [GRACE_W*N_BANKS-1:0] pump_grace,
    input  logic [N_BANKS-1:0]         pump_sleep_req,
    input  logic [OWN_W-1:0]           pump_owner,
    output logic [2*N_BANKS-1:0]       bank_mode,
    output logic [1:0]                 pump_mode,
    output logic                       pump_ready
);
    logic [N_BANKS-1:0] bank_active;
    logic [N_BANKS-1:0] bank_sleep;
    logic [GRACE_W-1:0] owner_grace;

    for (genvar i = 0; i < N_BANKS; i++) begin : g_bank
        fpf_bank_fsm #(.GRACE_W(GRACE_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .access    (bank_access[i]),
            .fallback  (bank_fallback[2*i +: 2]),
            .grace     (bank_grace[GRACE_W*i +: GRACE_W]),
            .mode      (bank_mode[2*i +: 2]),
            .is_active (bank_active[i]),
            .is_sleep  (bank_sleep[i])
        );
    end

    // Owner select; an out-of-range index falls back to controller 0.
    always_comb begin
        owner_grace = pump_grace[GRACE_W-1:0];
        for (int i = 1; i < N_BANKS; i++) begin
            if (pump_owner == OWN_W'(i)) owner_grace = pump_grace[GRACE_W*i +: GRACE_W];
        end
    end

    fpf_pump_fsm #(.GRACE_W(GRACE_W)) u_pump (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_access (|bank_access),
        .any_active (|bank_active),
        .all_sleep  (&bank_sleep),
        .all_req    (&pump_sleep_req),
        .grace      (owner_grace),
        .mode       (pump_mode),
        .ready      (pump_ready)
    );
endmodule

// File: rtl/fpf_checker.sv
module fpf_checker #(
    parameter int N_BANKS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_BANKS-1:0]   bank_access,
    input logic [2*N_BANKS-1:0] bank_fallback,
    input logic [N_BANKS-1:0]   pump_sleep_req,
    input logic [2*N_BANKS-1:0] bank_mode,
    input logic [1:0]           pump_mode
);
    logic all_asleep;
    logic any_awake;

    always_comb begin
        all_asleep = 1'b1;
        any_awake  = 1'b0;
        for (int i = 0; i < N_BANKS; i++) begin
            if (bank_mode[2*i +: 2] != 2'b00) all_asleep = 1'b0;
            if (bank_mode[2*i +: 2] == 2'b11) any_awake  = 1'b1;
        end
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_chk
        assert_access_wakes_R4: assert property (@(posedge clk) disable iff (!rst_n)
            bank_access[b] |=> bank_mode[2*b +: 2] == 2'b11);

        assert_active_code_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_fallback[2*b +: 2] inside {2'b10, 2'b11}) && bank_mode[2*b +: 2] == 2'b11
            |=> bank_mode[2*b +: 2] == 2'b11);

        assert_no_spare_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
            bank_mode[2*b +: 2] != 2'b10);

        assert_drop_after_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_mode[2*b +: 2] != 2'b11) && ($past(bank_mode[2*b +: 2]) == 2'b11)
            |-> !$past(bank_access[b]));
    end

    assert_pump_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_access) |=> pump_mode == 2'b11);

    assert_pump_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_awake |=> pump_mode == 2'b11);

    assert_pump_sleep_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_mode == 2'b00) |-> $past(all_asleep && (&pump_sleep_req)));
endmodule

bind flash_pwr_fallback fpf_checker #(.N_BANKS(N_BANKS)) u_fpf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .bank_access    (bank_access),
    .bank_fallback  (bank_fallback),
    .pump_sleep_req (pump_sleep_req),
    .bank_mode      (bank_mode),
    .pump_mode      (pump_mode)
);

// File: tb/tb_flash_pwr_fallback.sv
`timescale 1ns/1ps
module tb_flash_pwr_fallback;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc = '0;
    logic [3:0]  fb = 4'hF;
    logic [15:0] bg = '0;
    logic [15:0] pg = '0;
    logic [1:0]  req = '0;
    logic        own = 1'b0;
    logic [3:0]  bank_mode;
    logic [1:0]  pump_mode;
    logic        pump_ready;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_pwr_fallback dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bank_access    (acc),
        .bank_fallback  (fb),
        .bank_grace     (bg),
        .pump_grace     (pg),
        .pump_sleep_req (req),
        .pump_owner     (own),
        .bank_mode      (bank_mode),
        .pump_mode      (pump_mode),
        .pump_ready     (pump_ready)
    );

    function automatic logic [1:0] bm(input int b);
        return bank_mode[2*b +: 2];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [1:0] m);
        acc = m;
        @(negedge clk);
        acc = '0;
    endtask

    task automatic bank_drop(input int b, output int n);
        n = 0;
        while (bm(b) == 2'b11 && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pump_drop(output int n);
        n = 0;
        while (pump_mode == 2'b11 && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic restore();
        fb  = 4'hF;
        req = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(bank_mode == 4'hF, "R1 bank modes", bank_mode, 15);
        chk(pump_mode == 2'b11, "R1 pump mode", pump_mode, 3);
        chk(pump_ready == 1'b1, "R1 pump_ready", pump_ready, 1);

        // R3 active and spare codes hold the banks active
        fb = 4'b1011;
        repeat (20) @(negedge clk);
        chk(bank_mode == 4'hF, "R3 active/spare hold", bank_mode, 15);
        restore();

        // R2/R3/R4 sweep: bank, fallback code, grace value
        for (int b = 0; b < 2; b++) begin
            for (int c = 0; c < 2; c++) begin
                for (int g = 0; g < 6; g++) begin
                    bg[8*b +: 8] = 8'(g);
                    fb[2*b +: 2] = 2'(c);
                    pulse(2'(1 << b));
                    bank_drop(b, n);
                    chk(n == g + 1, "R2 bank drop delay", n, g + 1);
                    chk(bm(b) == 2'(c), "R3 bank fallback mode", bm(b), c);
                    pulse(2'(1 << b));
                    chk(bm(b) == 2'b11, "R4 wake on access", bm(b), 3);
                    restore();
                end
            end
        end

        // R5 grace rewrite during countdown
        bg[7:0] = 8'd10;
        fb[1:0] = 2'b00;
        pulse(2'b01);
        repeat (3) @(negedge clk);
        bg[7:0] = 8'd2;
        bank_drop(0, n);
        chk(n + 3 == 11, "R5 running count kept", n + 3, 11);
        pulse(2'b01);
        bank_drop(0, n);
        chk(n == 3, "R5 new value on next access", n, 3);
        restore();

        // R11 low-power bank follows its fallback code
        bg[15:8] = 8'd0;
        fb[3:2]  = 2'b01;
        pulse(2'b10);
        bank_drop(1, n);
        chk(bm(1) == 2'b01, "R11 standby reached", bm(1), 1);
        fb[3:2] = 2'b00;
        @(negedge clk);
        chk(bm(1) == 2'b00, "R11 standby to sleep", bm(1), 0);
        fb[3:2] = 2'b10;
        @(negedge clk);
        chk(bm(1) == 2'b11, "R11 spare code wakes", bm(1), 3);
        restore();

        // R6/R8/R10 pump sweep over owner and pump grace
        for (int o = 0; o < 2; o++) begin
            for (int p = 0; p < 5; p++) begin
                own = 1'(o);
                pg[8*o +: 8]     = 8'(p);
                pg[8*(1-o) +: 8] = 8'(p + 7);
                bg = {8'd3, 8'd1};
                fb = 4'b0101;
                req = '0;
                pulse(2'b11);
                chk(pump_ready == 1'b1, "R10 ready while active", pump_ready, 1);
                pump_drop(n);
                chk(n == p + 5, "R6 R8 pump drop delay", n, p + 5);
                chk(pump_mode == 2'b01, "R7 pump standby", pump_mode, 1);
                chk(pump_ready == 1'b0, "R10 ready low", pump_ready, 0);
                restore();
                chk(pump_mode == 2'b11, "R6 pump back active", pump_mode, 3);
            end
        end

        // R7 pump sleep gating
        pg = '0;
        bg = '0;
        fb = 4'b0000;
        req = 2'b11;
        pulse(2'b11);
        pump_drop(n);
        chk(n == 2, "R7 pump drop delay", n, 2);
        chk(pump_mode == 2'b00, "R7 pump sleep", pump_mode, 0);
        req = 2'b01;
        @(negedge clk);
        chk(pump_mode == 2'b01, "R7 request withdrawn", pump_mode, 1);
        req = 2'b11;
        @(negedge clk);
        chk(pump_mode == 2'b00, "R7 request restored", pump_mode, 0);
        // R9 access wakes the pump
        pulse(2'b10);
        chk(pump_mode == 2'b11, "R9 pump wake", pump_mode, 3);
        chk(pump_ready == 1'b1, "R10 ready after wake", pump_ready, 1);
        restore();

        req = 2'b01;
        fb = 4'b0000;
        pulse(2'b11);
        pump_drop(n);
        chk(pump_mode == 2'b01, "R7 partial request", pump_mode, 1);
        restore();

        req = 2'b11;
        fb = 4'b0001;
        pulse(2'b11);
        pump_drop(n);
        chk(pump_mode == 2'b01, "R7 one bank in standby", pump_mode, 1);
        restore();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule